// File: doc/BRIEF.md
# Thread-Enable Control Instruction Unit

This unit recognises two 32-bit instruction words that switch concurrent thread execution on or off. Either one reads the thread-control register, returns that value on a register-file write port, and writes the threads-enable bit with the variant's value, all on one clock edge. The read and the update cannot be split. The surrounding pipeline supplies the word with a valid strobe, a coprocessor-access flag and a flag that says whether multi-threading exists. It also supplies a cancel input for an interrupt or fault that arrives in the same cycle.

The unit checks for a missing feature first and for denied coprocessor access second. It raises at most one exception per word, and a word that raises one changes no state. A separate software write path loads the control register. A small tracker watches later reads of the control register. If such a read comes after an update with no hazard-barrier instruction in between, the tracker raises a stale-read flag. The flag stays up until a barrier is seen.

Top module: `te_ctl_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ctl_o` is all zeros, `te_o` is 0 and `rf_we_o`, `exc_ri_o`, `exc_cu_o` and `stale_rd_o` are 0.
- R2: A recognised word has bits [31:26]=000000, bits [20:16]=00000 and bits [5:0]=111100. If bits [15:6] equal 0000010101 (disable), and the word is valid, allowed and not cancelled, then in the cycle after the edge: `rf_we_o`=1, `rf_addr_o` = bits [25:21], `rf_data_o` = the control value from before the edge, and control bit `TE_BIT` is 0.
- R3: The same sequence with bits [15:6] equal to the `MINOR_EN` parameter (default 0000110101) sets control bit `TE_BIT` to 1.
- R4: When bits [25:21] are 0, `rf_we_o` stays 0, but the enable bit is still written.
- R5: Every control bit other than `TE_BIT` keeps its value across an executed word. `te_o` always equals `ctl_o[TE_BIT]`.
- R6: A recognised word with `mt_impl_i`=0 pulses `exc_ri_o` for one cycle, whatever `cop_en_i` is. `exc_cu_o` and `rf_we_o` stay 0 and the control register is unchanged.
- R7: A recognised word with `mt_impl_i`=1 and `cop_en_i`=0 pulses `exc_cu_o` for one cycle. `rf_we_o` stays 0 and the control register is unchanged.
- R8: A word that differs in the major opcode, the zero field, the extension opcode or the minor opcode has no effect. No write and no exception follow.
- R9: A word presented with `abort_i`=1 is dropped as a whole. No write, no bit change and no exception follow.
- R10: A `ctl_rd_i` pulse after an executed update, with no `barrier_i` since that update, sets `stale_rd_o` from the next cycle. The flag holds until the cycle after a `barrier_i` pulse, when it reads 0.
- R11: When `barrier_i` comes between the update and the read, `stale_rd_o` stays 0.
- R12: `ctl_wr_i` loads `ctl_wdata_i` into the control register, visible the next cycle. The load is ignored in a cycle that carries a recognised word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word |
| instr_vld_i | input | 1 | Instruction word is valid |
| abort_i | input | 1 | Cancels this cycle's instruction |
| cop_en_i | input | 1 | Coprocessor access is enabled |
| mt_impl_i | input | 1 | Multi-threading is implemented |
| ctl_wr_i | input | 1 | Software load of the control register |
| ctl_wdata_i | input | 32 | Data for the software load |
| barrier_i | input | 1 | A hazard-barrier instruction was issued |
| ctl_rd_i | input | 1 | A read of the control register was issued |
| rf_we_o | output | 1 | Register-file write enable |
| rf_addr_o | output | 5 | Register-file write address |
| rf_data_o | output | 32 | Old control value to be written |
| ctl_o | output | 32 | Current control register |
| te_o | output | 1 | Threads-enable bit |
| exc_ri_o | output | 1 | Reserved-instruction exception pulse |
| exc_cu_o | output | 1 | Coprocessor-unusable exception pulse |
| stale_rd_o | output | 1 | Read issued before a barrier closed the hazard |

## Verification
A wrong classification shows up one cycle after the edge that takes the word. It appears either as the wrong exception pulse or as a write pulse that should not be there. A broken read-modify-write shows up in the same cycle as a `rf_data_o` that does not match the prior control value, or as a change to bits outside the enable bit. A wrong hazard flag cannot be seen until a control read arrives, and it then stays visible until the next barrier.

// File: rtl/te_pkg.sv
package te_pkg;
  localparam int CTL_W = 32;
  localparam int RT_W  = 5;
  localparam logic [5:0] MAJOR_OP  = 6'b000000;
  localparam logic [5:0] EXT_OP    = 6'b111100;
  localparam logic [9:0] MINOR_DIS = 10'b0000010101;

  typedef struct packed {
    logic [5:0]      major;
    logic [RT_W-1:0] rt;
    logic [4:0]      zfield;
    logic [9:0]      minor;
    logic [5:0]      ext;
  } te_instr_t;

  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_EXEC = 2'd1,
    OUT_RI   = 2'd2,
    OUT_CU   = 2'd3
  } te_outcome_t;

  // Fixed priority: missing feature, then denied access, then execute.
  function automatic te_outcome_t te_classify(input logic hit, input logic mt,
                                              input logic cop);
    te_outcome_t r;
    if (!hit)      r = OUT_NONE;
    else if (!mt)  r = OUT_RI;
    else if (!cop) r = OUT_CU;
    else           r = OUT_EXEC;
    return r;
  endfunction

  // Write the enable bit with the set/clear value and keep every other bit.
  function automatic logic [CTL_W-1:0] te_apply(input logic [CTL_W-1:0] old,
                                                input logic set_val,
                                                input int unsigned pos);
    logic [CTL_W-1:0] r;
    r = old;
    r[pos] = set_val;
    return r;
  endfunction
endpackage

// File: rtl/te_decode.sv
module te_decode
  import te_pkg::*;
#(
  parameter logic [9:0] MINOR_EN = 10'b0000110101
) (
  input  logic [CTL_W-1:0] instr_i,
  input  logic             vld_i,
  input  logic             abort_i,
  output logic             hit_o,
  output logic             set_o,
  output logic [RT_W-1:0]  rt_o
);
  te_instr_t w;
  logic      frame_ok;
  logic      is_dis;
  logic      is_en;

  always_comb begin
    w        = te_instr_t'(instr_i);
    frame_ok = (w.major == MAJOR_OP) && (w.zfield == 5'd0) && (w.ext == EXT_OP);
    is_dis   = (w.minor == MINOR_DIS);
    is_en    = (w.minor == MINOR_EN);
    hit_o    = vld_i && !abort_i && frame_ok && (is_dis || is_en);
    set_o    = is_en;
    rt_o     = w.rt;
  end
endmodule

// File: rtl/te_ctl_reg.sv
module te_ctl_reg
  import te_pkg::*;
#(
  parameter int TE_BIT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_i,
  input  logic             set_i,
  input  logic             busy_i,
  input  logic             sw_wr_i,
  input  logic [CTL_W-1:0] sw_data_i,
  output logic [CTL_W-1:0] ctl_o
);
  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (exec_i)                 ctl_d = te_apply(ctl_q, set_i, TE_BIT);
    else if (sw_wr_i && !busy_i) ctl_d = sw_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/te_hazard.sv
module te_hazard (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic rd_i,
  input  logic barrier_i,
  output logic pending_o,
  output logic stale_o
);
  logic pend_q;
  logic stale_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      // A barrier in the same cycle as an update does not cover that update.
      if (upd_i)          pend_q <= 1'b1;
      else if (barrier_i) pend_q <= 1'b0;
      // A barrier is taken as ordered before a read in the same cycle.
      if (barrier_i)                 stale_q <= 1'b0;
      else if (rd_i && pend_q)       stale_q <= 1'b1;
    end
  end

  assign pending_o = pend_q;
  assign stale_o   = stale_q;
endmodule

// File: rtl/te_ctl_unit.sv
module te_ctl_unit
  import te_pkg::*;
#(
  parameter int         TE_BIT   = 15,
  parameter logic [9:0] MINOR_EN = 10'b0000110101
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CTL_W-1:0]     instr_i,
  input  logic                 instr_vld_i,
  input  logic                 abort_i,
  input  logic                 cop_en_i,
  input  logic                 mt_impl_i,
  input  logic                 ctl_wr_i,
  input  logic [CTL_W-1:0]     ctl_wdata_i,
  input  logic                 barrier_i,
  input  logic                 ctl_rd_i,
  output logic                 rf_we_o,
  output logic [RT_W-1:0]      rf_addr_o,
  output logic [CTL_W-1:0]     rf_data_o,
  output logic [CTL_W-1:0]     ctl_o,
  output logic                 te_o,
  output logic                 exc_ri_o,
  output logic                 exc_cu_o,
  output logic                 stale_rd_o
);
  logic            dec_hit;
  logic            dec_set;
  logic [RT_W-1:0] dec_rt;
  te_outcome_t     outcome;
  logic            exec_evt;
  logic            ri_evt;
  logic            cu_evt;
  logic [CTL_W-1:0] ctl_q;
  logic            haz_pending;

  te_decode #(.MINOR_EN(MINOR_EN)) dec_i (
    .instr_i (instr_i),
    .vld_i   (instr_vld_i),
    .abort_i (abort_i),
    .hit_o   (dec_hit),
    .set_o   (dec_set),
    .rt_o    (dec_rt)
  );

  always_comb begin
    outcome  = te_classify(dec_hit, mt_impl_i, cop_en_i);
    exec_evt = (outcome == OUT_EXEC);
    ri_evt   = (outcome == OUT_RI);
    cu_evt   = (outcome == OUT_CU);
  end

  te_ctl_reg #(.TE_BIT(TE_BIT)) reg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_i    (exec_evt),
    .set_i     (dec_set),
    .busy_i    (dec_hit),
    .sw_wr_i   (ctl_wr_i),
    .sw_data_i (ctl_wdata_i),
    .ctl_o     (ctl_q)
  );

  te_hazard haz_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_i     (exec_evt),
    .rd_i      (ctl_rd_i),
    .barrier_i (barrier_i),
    .pending_o (haz_pending),
    .stale_o   (stale_rd_o)
  );

  // Register-file port and exception pulses are captured on the same edge
  // that updates the control register, so both halves land together.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_we_o   <= 1'b0;
      rf_addr_o <= '0;
      rf_data_o <= '0;
      exc_ri_o  <= 1'b0;
      exc_cu_o  <= 1'b0;
    end else begin
      rf_we_o  <= exec_evt && (dec_rt != '0);
      exc_ri_o <= ri_evt;
      exc_cu_o <= cu_evt;
      if (exec_evt) begin
        rf_addr_o <= dec_rt;
        rf_data_o <= ctl_q;
      end
    end
  end

  assign ctl_o = ctl_q;
  assign te_o  = ctl_q[TE_BIT];
endmodule

// File: rtl/te_ctl_unit_chk.sv
module te_ctl_unit_chk
  import te_pkg::*;
#(
  parameter int TE_BIT = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_vld_i,
  input logic             abort_i,
  input logic             barrier_i,
  input logic             exec_evt,
  input logic             dec_set,
  input logic [RT_W-1:0]  dec_rt,
  input logic             rf_we_o,
  input logic [CTL_W-1:0] rf_data_o,
  input logic [CTL_W-1:0] ctl_o,
  input logic             exc_ri_o,
  input logic             exc_cu_o,
  input logic             stale_rd_o
);
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_ri_o, exc_cu_o, rf_we_o}));

  p_old_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_evt |=> (rf_data_o == $past(ctl_o)));

  p_bit_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_evt |=> (ctl_o[TE_BIT] == $past(dec_set)));

  p_rt_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_evt && dec_rt == '0) |=> !rf_we_o);

  p_exc_keeps_ctl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ri_o || exc_cu_o) |-> $stable(ctl_o));

  p_abort_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld_i && abort_i) |=> (!rf_we_o && !exc_ri_o && !exc_cu_o));

  p_barrier_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    barrier_i |=> !stale_rd_o);
endmodule

bind te_ctl_unit te_ctl_unit_chk #(.TE_BIT(TE_BIT)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_vld_i (instr_vld_i),
  .abort_i     (abort_i),
  .barrier_i   (barrier_i),
  .exec_evt    (exec_evt),
  .dec_set     (dec_set),
  .dec_rt      (dec_rt),
  .rf_we_o     (rf_we_o),
  .rf_data_o   (rf_data_o),
  .ctl_o       (ctl_o),
  .exc_ri_o    (exc_ri_o),
  .exc_cu_o    (exc_cu_o),
  .stale_rd_o  (stale_rd_o)
);

// File: tb/te_ctl_unit_tb_top.sv
module te_ctl_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i = '0;
  logic        instr_vld_i = 1'b0;
  logic        abort_i = 1'b0;
  logic        cop_en_i = 1'b1;
  logic        mt_impl_i = 1'b1;
  logic        ctl_wr_i = 1'b0;
  logic [31:0] ctl_wdata_i = '0;
  logic        barrier_i = 1'b0;
  logic        ctl_rd_i = 1'b0;
  logic        rf_we_o;
  logic [4:0]  rf_addr_o;
  logic [31:0] rf_data_o;
  logic [31:0] ctl_o;
  logic        te_o;
  logic        exc_ri_o;
  logic        exc_cu_o;
  logic        stale_rd_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_ctl = '0;

  localparam logic [9:0] DIS = 10'b0000010101;
  localparam logic [9:0] ENA = 10'b0000110101;
  localparam logic [31:0] TE_MASK = 32'h0000_8000;

  always #2.5 clk = ~clk;

  te_ctl_unit dut_i (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .instr_vld_i(instr_vld_i),
    .abort_i(abort_i), .cop_en_i(cop_en_i), .mt_impl_i(mt_impl_i),
    .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .barrier_i(barrier_i),
    .ctl_rd_i(ctl_rd_i), .rf_we_o(rf_we_o), .rf_addr_o(rf_addr_o),
    .rf_data_o(rf_data_o), .ctl_o(ctl_o), .te_o(te_o), .exc_ri_o(exc_ri_o),
    .exc_cu_o(exc_cu_o), .stale_rd_o(stale_rd_o)
  );

  function automatic logic [31:0] mk(input logic [4:0] rt, input logic [9:0] mn);
    return {6'b000000, rt, 5'b00000, mn, 6'b111100};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input logic [31:0] w, input logic cop, input logic mt,
                       input logic ab);
    instr_i = w; instr_vld_i = 1'b1; cop_en_i = cop; mt_impl_i = mt; abort_i = ab;
    cyc();
    instr_vld_i = 1'b0; cop_en_i = 1'b1; mt_impl_i = 1'b1; abort_i = 1'b0;
  endtask

  task automatic t_reset();
    cyc(); cyc();
    chk("R1", "ctl in reset", ctl_o, 32'h0);
    chk("R1", "flags in reset", {27'd0, rf_we_o, te_o, exc_ri_o, exc_cu_o, stale_rd_o}, 32'h0);
    rst_n = 1'b1;
    cyc();
    chk("R1", "ctl after reset", ctl_o, 32'h0);
    chk("R1", "flags after reset", {27'd0, rf_we_o, te_o, exc_ri_o, exc_cu_o, stale_rd_o}, 32'h0);
  endtask

  task automatic t_load();
    ctl_wr_i = 1'b1; ctl_wdata_i = 32'hA5A5_0F0F;
    cyc();
    ctl_wr_i = 1'b0;
    m_ctl = 32'hA5A5_0F0F;
    chk("R12", "software load", ctl_o, m_ctl);
  endtask

  task automatic t_exec(input logic [4:0] rt, input logic en, input string req);
    logic [31:0] old;
    old = m_ctl;
    m_ctl = en ? (m_ctl | TE_MASK) : (m_ctl & ~TE_MASK);
    issue(mk(rt, en ? ENA : DIS), 1'b1, 1'b1, 1'b0);
    chk(req, "write enable", {31'd0, rf_we_o}, {31'd0, rt != 5'd0});
    if (rt != 5'd0) begin
      chk(req, "write address", {27'd0, rf_addr_o}, {27'd0, rt});
      chk(req, "old value returned", rf_data_o, old);
    end
    chk(req, "control after update", ctl_o, m_ctl);
    chk("R5", "te mirrors bit", {31'd0, te_o}, {31'd0, en});
    cyc();
    chk(req, "write is one pulse", {31'd0, rf_we_o}, 32'd0);
  endtask

  task automatic t_exc(input logic cop, input logic mt, input string req);
    issue(mk(5'd9, DIS), cop, mt, 1'b0);
    chk(req, "ri flag", {31'd0, exc_ri_o}, {31'd0, !mt});
    chk(req, "cu flag", {31'd0, exc_cu_o}, {31'd0, mt && !cop});
    chk(req, "no write", {31'd0, rf_we_o}, 32'd0);
    chk(req, "control kept", ctl_o, m_ctl);
    cyc();
    chk(req, "exception is one pulse", {30'd0, exc_ri_o, exc_cu_o}, 32'd0);
  endtask

  task automatic t_nomatch();
    logic [31:0] w [4];
    w[0] = mk(5'd3, 10'b0000010100);
    w[1] = mk(5'd3, DIS) | 32'h0001_0000;
    w[2] = mk(5'd3, ENA) ^ 32'h0000_0001;
    w[3] = mk(5'd3, DIS) | 32'h0400_0000;
    for (int i = 0; i < 4; i++) begin
      issue(w[i], 1'b1, 1'b1, 1'b0);
      chk("R8", "no write or exception", {29'd0, rf_we_o, exc_ri_o, exc_cu_o}, 32'd0);
      chk("R8", "control kept", ctl_o, m_ctl);
    end
  endtask

  task automatic t_abort();
    issue(mk(5'd4, DIS), 1'b1, 1'b1, 1'b1);
    chk("R9", "no write", {31'd0, rf_we_o}, 32'd0);
    chk("R9", "bit kept", ctl_o, m_ctl);
    issue(mk(5'd4, DIS), 1'b1, 1'b0, 1'b1);
    chk("R9", "no exception", {30'd0, exc_ri_o, exc_cu_o}, 32'd0);
  endtask

  task automatic t_hazard();
    barrier_i = 1'b1; cyc(); barrier_i = 1'b0;
    t_exec(5'd1, 1'b0, "R2");
    barrier_i = 1'b1; cyc(); barrier_i = 1'b0;
    ctl_rd_i = 1'b1; cyc(); ctl_rd_i = 1'b0;
    chk("R11", "read after barrier", {31'd0, stale_rd_o}, 32'd0);
    cyc();
    chk("R11", "still clean", {31'd0, stale_rd_o}, 32'd0);
    t_exec(5'd2, 1'b1, "R3");
    ctl_rd_i = 1'b1; cyc(); ctl_rd_i = 1'b0;
    chk("R10", "stale read flagged", {31'd0, stale_rd_o}, 32'd1);
    cyc();
    chk("R10", "flag held", {31'd0, stale_rd_o}, 32'd1);
    barrier_i = 1'b1; cyc(); barrier_i = 1'b0;
    chk("R10", "barrier clears flag", {31'd0, stale_rd_o}, 32'd0);
  endtask

  task automatic t_busy_load();
    ctl_wr_i = 1'b1; ctl_wdata_i = 32'h1234_5678;
    issue(mk(5'd6, DIS), 1'b0, 1'b1, 1'b0);
    ctl_wr_i = 1'b0;
    chk("R12", "load ignored with word", ctl_o, m_ctl);
  endtask

  initial begin
    t_reset();
    t_load();
    t_exec(5'd5, 1'b1, "R3");
    t_exec(5'd7, 1'b0, "R2");
    t_exec(5'd0, 1'b1, "R4");
    t_exc(1'b0, 1'b0, "R6");
    t_exc(1'b1, 1'b0, "R6");
    t_exc(1'b0, 1'b1, "R7");
    t_nomatch();
    t_abort();
    t_busy_load();
    t_hazard();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule